// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog and interval timer. It counts upward on a strobe taken from a free-running prescaler. The prescaler divides the block clock by one of eight fixed ratios. The timer has two 8-bit registers on a small 16-bit register bus: an up-counter and a control/status register. Software must refresh the counter before it wraps. If the counter wraps from its maximum value to zero, the block sets an overflow flag. In watchdog mode it then drives a reset pulse of fixed length. In interval mode it raises an interrupt request instead.

Stray writes could silence a watchdog, so both registers are protected. A register accepts a write only when the transfer is a full 16-bit word and its upper byte carries the key that belongs to the addressed register. The lower byte is the data. Every other write leaves all state untouched. Reads are always allowed.

The bus has no stream data path, so there is no valid/ready handshake. A write is a single-cycle strobe and is never stalled. Read data is combinational from the address.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, the counter reads 0x00, the control register reads 0x00, and both `wdg_rst_o` and `wdg_irq_o` are low.
- R2: A write to address 0 loads the lower data byte into the counter only if `bus_size` is 01 (word) and the upper data byte is 0x5A. Any other upper byte leaves the counter unchanged.
- R3: A write to address 1 updates the control register only if `bus_size` is 01 and the upper data byte is 0xA5. The control fields are bit 7 enable, bit 6 mode (1 = interval interrupt, 0 = watchdog reset), bit 5 overflow flag and bits 2:0 clock select. Bits 4:3 always read as 0.
- R4: Writes with `bus_size` 00 (byte), 10 (32-bit) or 11 change no state, even when they carry the correct key.
- R5: Clock-select codes 0 to 7 divide by 1, 4, 16, 32, 64, 256, 1024 and 4096. After the edge that sets enable, the counter steps once every divisor cycles. The first step lands exactly one divisor after that edge.
- R6: While enable is 0, the counter holds its value.
- R7: A count step from 0xFF to 0x00 sets the overflow flag. Only a keyed control write with bit 5 = 0 clears the flag. Writing 1 to bit 5 never sets it.
- R8: In interval mode, `wdg_irq_o` goes high on the edge that sets the flag and stays high while the flag is set.
- R9: In watchdog mode, an overflow drives `wdg_rst_o` high for RST_CYC (default 8) cycles, starting on the overflow edge. `wdg_irq_o` stays low in this mode.
- R10: Reads return the addressed register in bits 7:0 with bits 15:8 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_addr | input | 1 | 0 = counter, 1 = control/status |
| bus_size | input | 2 | 00 byte, 01 word, 10 32-bit |
| bus_wdata | input | 16 | Key byte in 15:8, data byte in 7:0 |
| bus_rdata | output | 16 | Addressed register, upper byte zero |
| wdg_rst_o | output | 1 | Reset pulse on watchdog-mode overflow |
| wdg_irq_o | output | 1 | Interrupt request in interval mode |

## Verification
The hardest states to reach from the ports are the wrap at the slow divisors and the overflow itself. At divide-by-4096, a full count from zero would take over a million cycles. The bench handles the divisor sweep by loading the counter to zero and checking the count one cycle before and exactly at three divisor periods, for every code. It reaches the overflow by loading the counter with a keyed write to a value just below 0xFF at divide-by-1, so the wrap edge arrives within a few cycles and the flag, interrupt and reset pulse can be checked cycle by cycle. Rejection of wrong keys is swept over all 255 wrong upper bytes on both addresses.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W   = 8;
  localparam int BUS_W    = 16;
  localparam int PRE_W    = 12;
  localparam int CKS_W    = 3;
  localparam logic [7:0] KEY_CNT  = 8'h5A;
  localparam logic [7:0] KEY_CTRL = 8'hA5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } bus_size_e;

  localparam int B_EN   = 7;
  localparam int B_MODE = 6;
  localparam int B_FLAG = 5;

  function automatic int cks_shift(input logic [CKS_W-1:0] code);
    case (code)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 8;
      3'd6: return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);
  localparam int NSEL = 1 << CKS_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask_tbl [NSEL];
  logic [PRE_W-1:0] mask;

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    assign mask_tbl[g] = PRE_W'((1 << cks_shift(CKS_W'(g))) - 1);
  end

  assign mask = mask_tbl[cks];
  assign tick = en && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (!en) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt,
  output logic              ovf
);
  localparam logic [DATA_W-1:0] CMAX = '1;

  assign ovf = tick && !load && (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              ovf,
  input  logic [DATA_W-1:0] cnt,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] cnt_wval,
  output logic              en,
  output logic              mode,
  output logic              flag,
  output logic [CKS_W-1:0]  cks,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic              word_ok;
  logic              ctrl_wr;
  logic [7:0]        key;
  logic [DATA_W-1:0] dat;
  logic [DATA_W-1:0] ctrl_view;

  assign key      = bus_wdata[BUS_W-1 -: 8];
  assign dat      = bus_wdata[DATA_W-1:0];
  assign word_ok  = bus_wr && (bus_size == SZ_WORD);
  assign cnt_wr   = word_ok && !bus_addr && (key == KEY_CNT);
  assign ctrl_wr  = word_ok &&  bus_addr && (key == KEY_CTRL);
  assign cnt_wval = dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= 1'b0;
      cks  <= '0;
    end else if (ctrl_wr) begin
      en   <= dat[B_EN];
      mode <= dat[B_MODE];
      cks  <= dat[CKS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flag <= 1'b0;
    else if (ovf)                    flag <= 1'b1;
    else if (ctrl_wr && !dat[B_FLAG]) flag <= 1'b0;
  end

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[B_EN]   = en;
    ctrl_view[B_MODE] = mode;
    ctrl_view[B_FLAG] = flag;
    ctrl_view[CKS_W-1:0] = cks;
  end

  assign bus_rdata = {{(BUS_W-DATA_W){1'b0}}, bus_addr ? ctrl_view : cnt};
endmodule

// File: rtl/wdg_rstpulse.sv
module wdg_rstpulse #(
  parameter int RST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int RCW = $clog2(RST_CYC + 1);
  logic [RCW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (fire)        left_q <= RCW'(RST_CYC);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != 0);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              wdg_rst_o,
  output logic              wdg_irq_o
);
  logic              tick, ovf, cnt_wr, en, mode, flag;
  logic [DATA_W-1:0] cnt, cnt_wval;
  logic [CKS_W-1:0]  cks;

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .ovf(ovf), .cnt(cnt),
    .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .en(en), .mode(mode),
    .flag(flag), .cks(cks), .bus_rdata(bus_rdata)
  );

  wdg_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .cks(cks), .tick(tick)
  );

  wdg_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr),
    .load_val(cnt_wval), .cnt(cnt), .ovf(ovf)
  );

  wdg_rstpulse #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(ovf && !mode), .pulse(wdg_rst_o)
  );

  assign wdg_irq_o = flag && mode;
endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        mode,
  input logic        flag,
  input logic        ovf,
  input logic        tick,
  input logic        cnt_wr,
  input logic [7:0]  cnt,
  input logic [15:0] bus_rdata,
  input logic        wdg_rst_o,
  input logic        wdg_irq_o
);
  // R5
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag);
  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && mode) |=> wdg_irq_o);
  // R9
  rst_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !mode) |=> wdg_rst_o);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !$past(mode)) |-> !wdg_irq_o);
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[15:8] == 8'h00);
endmodule

bind wdg_keyed_top wdg_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .flag(flag),
  .ovf(ovf), .tick(tick), .cnt_wr(cnt_wr), .cnt(cnt),
  .bus_rdata(bus_rdata), .wdg_rst_o(wdg_rst_o), .wdg_irq_o(wdg_irq_o)
);

// File: tb/wdg_keyed_top_tb.sv
module wdg_keyed_top_tb;
  localparam int RST_CYC = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_addr = 1'b0;
  logic [1:0] bus_size = 2'b01;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic wdg_rst_o, wdg_irq_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  wdg_keyed_top #(.RST_CYC(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdg_rst_o(wdg_rst_o), .wdg_irq_o(wdg_irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] sz, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 2'b01;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int div_of(input int c);
    int t [8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
    return t[c];
  endfunction

  initial begin : wd
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 cnt", v, 16'h0000);
    rd(1, v); chk("R1 ctrl", v, 16'h0000);
    chk("R1 rst", {15'd0, wdg_rst_o}, 16'd0);
    chk("R1 irq", {15'd0, wdg_irq_o}, 16'd0);

    // R2 keyed counter write
    wr(0, 2'b01, 16'h5A11);
    rd(0, v); chk("R2 load", v, 16'h0011);
    for (int k = 0; k < 256; k++) begin
      if (k != 8'h5A) begin
        wr(0, 2'b01, {k[7:0], 8'h99});
        rd(0, v); chk("R2 badkey", v, 16'h0011);
      end
    end
    // R3 keyed control write
    for (int k = 0; k < 256; k++) begin
      if (k != 8'hA5) begin
        wr(1, 2'b01, {k[7:0], 8'hC7});
        rd(1, v); chk("R3 badkey", v, 16'h0000);
      end
    end
    // R4 wrong sizes
    for (int s = 0; s < 4; s++) begin
      if (s != 1) begin
        wr(0, s[1:0], 16'h5A77);
        rd(0, v); chk("R4 cnt size", v, 16'h0011);
        wr(1, s[1:0], 16'hA5C3);
        rd(1, v); chk("R4 ctrl size", v, 16'h0000);
      end
    end
    // R3 layout, R10 upper byte zero
    wr(1, 2'b01, 16'hA5FF);
    rd(1, v); chk("R3 R10 ctrl view", v, 16'h00C7);
    wr(1, 2'b01, 16'hA500);
    // R6 hold while disabled
    wr(0, 2'b01, 16'h5A42);
    repeat (20) @(negedge clk);
    rd(0, v); chk("R6 hold", v, 16'h0042);

    // R5 divisor sweep
    for (int c = 0; c < 8; c++) begin
      wr(1, 2'b01, 16'hA500);
      wr(0, 2'b01, 16'h5A00);
      wr(1, 2'b01, {8'hA5, 8'hC0 | 8'(c)});
      repeat (3 * div_of(c) - 1) @(negedge clk);
      rd(0, v); chk($sformatf("R5 code%0d before", c), v, 16'd2);
      @(negedge clk);
      rd(0, v); chk($sformatf("R5 code%0d at", c), v, 16'd3);
    end
    wr(1, 2'b01, 16'hA500);

    // R7 R8 interval overflow
    wr(0, 2'b01, 16'h5AFD);
    wr(1, 2'b01, 16'hA5C0);
    repeat (2) @(negedge clk);
    rd(1, v); chk("R7 flag pre", {15'd0, v[5]}, 16'd0);
    chk("R8 irq pre", {15'd0, wdg_irq_o}, 16'd0);
    @(negedge clk);
    rd(1, v); chk("R7 flag set", {15'd0, v[5]}, 16'd1);
    rd(0, v); chk("R7 wrap", v, 16'h0000);
    chk("R8 irq set", {15'd0, wdg_irq_o}, 16'd1);
    chk("R9 no rst interval", {15'd0, wdg_rst_o}, 16'd0);
    wr(1, 2'b01, 16'hA460);
    rd(1, v); chk("R7 badkey keeps flag", {15'd0, v[5]}, 16'd1);
    chk("R8 irq held", {15'd0, wdg_irq_o}, 16'd1);
    wr(1, 2'b01, 16'hA540);
    rd(1, v); chk("R7 clear", {15'd0, v[5]}, 16'd0);
    chk("R8 irq drop", {15'd0, wdg_irq_o}, 16'd0);
    wr(1, 2'b01, 16'hA560);
    rd(1, v); chk("R7 one no set", {15'd0, v[5]}, 16'd0);

    // R9 watchdog reset pulse
    wr(1, 2'b01, 16'hA500);
    wr(0, 2'b01, 16'h5AFE);
    wr(1, 2'b01, 16'hA580);
    @(negedge clk);
    chk("R9 rst pre", {15'd0, wdg_rst_o}, 16'd0);
    @(negedge clk);
    chk("R9 rst start", {15'd0, wdg_rst_o}, 16'd1);
    chk("R9 irq low", {15'd0, wdg_irq_o}, 16'd0);
    repeat (RST_CYC - 1) @(negedge clk);
    chk("R9 rst last", {15'd0, wdg_rst_o}, 16'd1);
    @(negedge clk);
    chk("R9 rst end", {15'd0, wdg_rst_o}, 16'd0);
    rd(1, v); chk("R7 flag wd mode", {15'd0, v[5]}, 16'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule